// File: doc/BRIEF.md
# Dual Configurable Decade Divider

The block holds two identical counter halves. Each half is made of a divide-by-2 section and a divide-by-5 section, and each section has its own count input. A two-bit mode input per half chooses how the sections are joined. They can run as two independent sections. They can form a binary-coded decade counter, where the divide-by-2 output feeds the divide-by-5 section. They can form a bi-quinary decade counter, where the divide-by-5 wrap feeds the divide-by-2 section, so that the low output bit becomes a square-wave decade output. A global cascade bit chains the decade carry of each half into the next half, which allows division down to one hundredth of the input rate.

All logic runs on one system clock. The count inputs are sampled through synchronizers and only their high-to-low transitions advance a section. No internal signal is ever used as a clock. Each half has an active-high clear input. The clear acts immediately, and its release is synchronized to the system clock.

Top module: `dcd_dual_divider`

## Requirements
- R1: A section advances only on a detected high-to-low transition of its count source. A low-to-high transition changes no output.
- R2: While a half's clear input is high, that half's four outputs are 0 without waiting for a clock edge, and count input edges have no effect. The other half keeps its count. After the clear is released, the first falling edge advances the half from 0.
- R3: Mode 2'b00 (and the unused code 2'b11) gives independent sections. Output bit 0 toggles on each falling edge of count input 0. Output bits 3:1 step 0,1,2,3,4 as a binary number and then wrap to 0 on falling edges of count input 1.
- R4: Mode 2'b01 gives the binary-coded decade. Count input 0 is the external input, and after n falling edges outputs 3:0 equal n mod 10 in binary. Count input 1 is ignored.
- R5: Mode 2'b10 gives the bi-quinary decade. Count input 1 is the external input. After n edges, with c = n mod 10, bits 3:1 equal c mod 5 and bit 0 is 1 exactly when c is 5 or more, which is a 50% duty decade output. Count input 0 is ignored.
- R6: When the cascade bit is 1, half k+1 takes the decade carry of half k as its external input in place of its own pin. That input is count input 0 in modes 00 and 01, and count input 1 in mode 10. The carry is the fall of bit 3 in mode 01 and the fall of bit 0 otherwise. This gives overall ratios of 4, 20 and 100.
- R7: An external falling edge first appears on the outputs at the third rising system clock edge after the low level is present. Each internal link between sections or halves adds exactly one more clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all count inputs |
| mr | input | N_HALVES | Per-half active-high clear, asynchronous assertion |
| cp0 | input | N_HALVES | Per-half count input of the divide-by-2 section |
| cp1 | input | N_HALVES | Per-half count input of the divide-by-5 section |
| mode | input | 2*N_HALVES | Per-half join mode; bits 2k+1:2k belong to half k |
| cascade | input | 1 | Chains each half's decade carry into the next half |
| q | output | 4*N_HALVES | Per-half count; bits 4k+3:4k belong to half k |

## Verification
The bench goes after the wrap points: 9 to 0 in the binary decade, 4 to 0 in the quinary section, and 9 to 0 in bi-quinary, where the decade bit must fall. A design that mis-wires a link would show counts of 10 or more, or a decade bit with the wrong duty. The bench also checks the pin that a mode or the cascade makes unused, because a design that leaks it would count extra. It applies a clear in the middle of a count while the other half holds a non-zero value, to catch a clear that waits for a clock or that spreads to both halves. Finally it counts the exact clock latency of a linked carry, which exposes a combinational link or a register missing from the synchronizer.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [1:0] {
    LINK_NONE = 2'b00,
    LINK_BCD  = 2'b01,
    LINK_BIQ  = 2'b10
  } link_mode_e;

  localparam int QUIN_MOD = 5;
  localparam int QUIN_W   = $clog2(QUIN_MOD);
  localparam int HALF_W   = QUIN_W + 1;

  // next state of the divide-by-5 section
  function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] v);
    if (v == QUIN_W'(QUIN_MOD - 1)) return '0;
    return v + 1'b1;
  endfunction

endpackage

// File: rtl/dcd_reset_sync.sv
module dcd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic mr,
  output logic rst
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or posedge mr) begin
    if (mr) pipe <= '1;
    else    pipe <= {pipe[STAGES-2:0], 1'b0};
  end

  assign rst = pipe[STAGES-1];
endmodule

// File: rtl/dcd_fall_det.sv
module dcd_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cp,
  output logic fall
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the one before it
  logic [STAGES:0] sh;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], cp};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/dcd_half.sv
module dcd_half
  import dcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              ext0_fall,
  input  logic              ext1_fall,
  input  logic              carry_in,
  input  logic              use_carry,
  output logic [HALF_W-1:0] q,
  output logic              carry_out
);
  logic              q0;
  logic [QUIN_W-1:0] q5;
  logic              q0_fall_p;   // registered fall of bit 0
  logic              q3_fall_p;   // registered wrap of the quinary section
  logic              is_bcd, is_biq;
  logic              pri;         // external (or cascaded) input strobe
  logic              adv2, adv5;  // section advance strobes

  assign is_bcd = (mode == LINK_BCD);
  assign is_biq = (mode == LINK_BIQ);

  assign pri  = use_carry ? carry_in : (is_biq ? ext1_fall : ext0_fall);
  assign adv2 = is_biq ? q3_fall_p : pri;
  assign adv5 = is_bcd ? q0_fall_p : (is_biq ? pri : ext1_fall);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q0        <= 1'b0;
      q5        <= '0;
      q0_fall_p <= 1'b0;
      q3_fall_p <= 1'b0;
    end else begin
      q0        <= q0 ^ adv2;
      q5        <= adv5 ? quin_next(q5) : q5;
      q0_fall_p <= adv2 & q0;
      q3_fall_p <= adv5 & q5[QUIN_W-1];
    end
  end

  assign q         = {q5, q0};
  assign carry_out = is_bcd ? q3_fall_p : q0_fall_p;
endmodule

// File: rtl/dcd_dual_divider.sv
module dcd_dual_divider
  import dcd_pkg::*;
#(
  parameter int N_HALVES    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic [N_HALVES-1:0]        mr,
  input  logic [N_HALVES-1:0]        cp0,
  input  logic [N_HALVES-1:0]        cp1,
  input  logic [2*N_HALVES-1:0]      mode,
  input  logic                       cascade,
  output logic [HALF_W*N_HALVES-1:0] q
);
  logic [N_HALVES-1:0] rst;
  logic [N_HALVES-1:0] fall0, fall1;
  logic [N_HALVES-1:0] carry;

  for (genvar g = 0; g < N_HALVES; g++) begin : g_half
    logic cin;
    logic use_c;

    dcd_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk (clk), .mr (mr[g]), .rst (rst[g])
    );
    dcd_fall_det #(.STAGES(SYNC_STAGES)) u_det0 (
      .clk (clk), .rst (rst[g]), .cp (cp0[g]), .fall (fall0[g])
    );
    dcd_fall_det #(.STAGES(SYNC_STAGES)) u_det1 (
      .clk (clk), .rst (rst[g]), .cp (cp1[g]), .fall (fall1[g])
    );

    if (g == 0) begin : g_first
      assign cin   = 1'b0;
      assign use_c = 1'b0;
    end else begin : g_chain
      assign cin   = carry[g-1];
      assign use_c = cascade;
    end

    dcd_half u_half (
      .clk       (clk),
      .rst       (rst[g]),
      .mode      (mode[2*g +: 2]),
      .ext0_fall (fall0[g]),
      .ext1_fall (fall1[g]),
      .carry_in  (cin),
      .use_carry (use_c),
      .q         (q[HALF_W*g +: HALF_W]),
      .carry_out (carry[g])
    );
  end
endmodule

// File: rtl/dcd_half_chk.sv
module dcd_half_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       adv2,
  input logic       adv5,
  input logic [3:0] q
);
  // R2: a synchronized clear holds the half at zero
  p_reset_clear_r2: assert property (@(posedge clk) rst |-> q == 4'd0);

  // R1: no strobe, no change
  p_hold_q0_r1: assert property (@(posedge clk) disable iff (rst)
    !adv2 |=> q[0] == $past(q[0]));
  p_hold_quin_r1: assert property (@(posedge clk) disable iff (rst)
    !adv5 |=> $stable(q[3:1]));

  // R3: section behaviour
  p_toggle_q0_r3: assert property (@(posedge clk) disable iff (rst)
    adv2 |=> q[0] != $past(q[0]));
  p_quin_step_r3: assert property (@(posedge clk) disable iff (rst)
    adv5 |=> q[3:1] == (($past(q[3:1]) == 3'd4) ? 3'd0 : $past(q[3:1]) + 3'd1));
  p_quin_range_r3: assert property (@(posedge clk) disable iff (rst)
    q[3:1] <= 3'd4);

  // R4: in decade mode a fall of bit 0 strobes the quinary section next cycle
  p_bcd_link_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(q[0]) && mode == 2'b01 && $past(mode) == 2'b01) |-> adv5);

  // R5: in bi-quinary mode a quinary wrap strobes bit 0 next cycle
  p_biq_link_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(q[3]) && mode == 2'b10 && $past(mode) == 2'b10) |-> adv2);
endmodule

bind dcd_half dcd_half_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .mode (mode),
  .adv2 (adv2),
  .adv5 (adv5),
  .q    (q)
);

// File: tb/dcd_dual_divider_bench.sv
module dcd_dual_divider_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [1:0] mr;
  logic [1:0] cp0, cp1;
  logic [3:0] mode;
  logic       cascade;
  logic [7:0] q;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcd_dual_divider u_dcd_dual_divider (
    .clk (clk), .mr (mr), .cp0 (cp0), .cp1 (cp1),
    .mode (mode), .cascade (cascade), .q (q)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] biq(input int n);
    int c;
    logic [2:0] hi;
    c  = n % 10;
    hi = 3'(c % 5);
    return {hi, c >= 5};
  endfunction

  function automatic logic [3:0] bcd(input int n);
    return 4'(n % 10);
  endfunction

  // one full input cycle on half h, then check the rising edge did nothing (R1)
  task automatic pulse(input int h, input bit on_cp1);
    logic [7:0] held;
    if (on_cp1) cp1[h] = 1'b0; else cp0[h] = 1'b0;
    tick(8);
    held = q;
    if (on_cp1) cp1[h] = 1'b1; else cp0[h] = 1'b1;
    tick(6);
    check("R1 rising edge", q, held);
  endtask

  task automatic clear_all();
    mr = 2'b11;
    tick(3);
    check("R2 clear", q, 8'h00);
    mr = 2'b00;
    tick(6);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog got=hung exp=finished");
      report();
    end
  end

  initial begin
    mr = 2'b11; cp0 = 2'b11; cp1 = 2'b11; mode = 4'b0000; cascade = 1'b0;
    tick(3);
    check("R2 reset state", q, 8'h00);
    mr = 2'b00;
    tick(6);

    // R3 independent sections on each half
    for (int h = 0; h < 2; h++) begin
      int n0, n1;
      logic [2:0] e5;
      n0 = 0; n1 = 0;
      clear_all();
      for (int i = 0; i < 24; i++) begin
        if (i % 3 == 0) begin pulse(h, 1'b1); n1++; end
        else            begin pulse(h, 1'b0); n0++; end
        e5 = 3'(n1 % 5);
        check("R3 independent", 8'(q[4*h +: 4]), 8'({e5, 1'(n0 % 2)}));
      end
    end

    // R4 binary-coded decade
    mode = 4'b0101;
    clear_all();
    for (int n = 1; n <= 25; n++) begin
      pulse(0, 1'b0);
      check("R4 decade count", 8'(q[3:0]), 8'(bcd(n)));
    end
    pulse(0, 1'b1);
    check("R4 cp1 ignored", 8'(q[3:0]), 8'(bcd(25)));

    // R7 exact latency: count 1 -> 2 passes through the internal link
    clear_all();
    pulse(0, 1'b0);
    cp0[0] = 1'b0;
    tick(2);
    check("R7 not before third edge", 8'(q[3:0]), 8'h1);
    tick(1);
    check("R7 bit0 at third edge", 8'(q[3:0]), 8'h0);
    tick(1);
    check("R7 link one clock later", 8'(q[3:0]), 8'h2);
    cp0[0] = 1'b1;
    tick(6);

    // R5 bi-quinary
    mode = 4'b1010;
    clear_all();
    for (int n = 1; n <= 25; n++) begin
      pulse(0, 1'b1);
      check("R5 bi-quinary count", 8'(q[3:0]), 8'(biq(n)));
    end
    pulse(0, 1'b0);
    check("R5 cp0 ignored", 8'(q[3:0]), 8'(biq(25)));

    // R2 clear in mid count, other half unaffected
    mode = 4'b0101;
    clear_all();
    for (int i = 0; i < 7; i++) pulse(0, 1'b0);
    for (int i = 0; i < 3; i++) pulse(1, 1'b0);
    check("R2 before clear", q, 8'h37);
    mr[0] = 1'b1;
    #1;
    check("R2 clear without clock", q, 8'h30);
    tick(1);
    pulse(0, 1'b0);
    check("R2 edges ignored while clear", q, 8'h30);
    mr[0] = 1'b0;
    tick(6);
    pulse(0, 1'b0);
    check("R2 resume after release", q, 8'h31);

    // R6 cascade: decade into decade, divide by 100
    cascade = 1'b1;
    mode = 4'b0101;
    clear_all();
    for (int n = 1; n <= 120; n++) begin
      pulse(0, 1'b0);
      check("R6 cascade decade", q, {bcd(n / 10), bcd(n)});
    end
    pulse(1, 1'b0);
    check("R6 second-half pin ignored", q, {bcd(12), bcd(120)});

    // R6 cascade: two divide-by-2 sections, divide by 4
    mode = 4'b0000;
    clear_all();
    for (int n = 1; n <= 12; n++) begin
      pulse(0, 1'b0);
      check("R6 cascade div4", q, {3'b000, 1'((n / 2) % 2), 3'b000, 1'(n % 2)});
    end

    // R6 cascade: bi-quinary into bi-quinary
    mode = 4'b1010;
    clear_all();
    for (int n = 1; n <= 50; n++) begin
      pulse(0, 1'b1);
      check("R6 cascade bi-quinary", q, {biq(n / 10), biq(n)});
    end
    pulse(1, 1'b1);
    check("R6 second-half cp1 ignored", q, {biq(5), biq(50)});

    // R6 cascade: bi-quinary into divide-by-2, divide by 20
    mode = 4'b0010;
    clear_all();
    for (int n = 1; n <= 40; n++) begin
      pulse(0, 1'b1);
      check("R6 cascade div20", q, {3'b000, 1'((n / 10) % 2), biq(n)});
    end

    done = 1;
    report();
  end
endmodule